// File: doc/BRIEF.md
# Dual-Alignment PWM Channel Generator

This block produces one pulse-width-modulated output. A channel counter advances on a tick. The tick is taken from one of eleven power-of-two taps of the system clock, or from one of two programmable linear dividers. In left-aligned mode the counter is a sawtooth that counts from 0 to P−1 and wraps. In center-aligned mode it is a triangle: it rises from 0 to P and falls back to 0, so the waveform is symmetric about the middle of the period. P is the period value.

The output holds the polarity level at the start of every period. It switches to the opposite level once the counter reaches the duty value D, and it switches back on the falling half when running centered. Period, duty and alignment values written while the channel runs are held back and take effect at the next period end, so a running waveform never shows a truncated or glitched period. A one-cycle period-end pulse marks each period boundary.

Top module: `pwm_chan_gen`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `pwm_o` and `prd_end_o` are both 0.
- R2: With `clk_sel_i` = k in 0..10 the counter ticks every X = 2^k clocks. In left-aligned mode (`align_i` = 0) each period lasts X·P clocks, and the output is at the level opposite to `pol_i` for X·(P−D) of them. Between ticks the output does not change.
- R3: In center-aligned mode (`align_i` = 1) each period lasts 2·X·P clocks, and the output is at the opposite level for 2·X·(P−D) of them.
- R4: Each period starts at the `pol_i` level: with `pol_i` = 1 the output is high while the counter is below D and low after that.
- R5: With D ≥ P the output stays at the `pol_i` level for the whole period. With D = 0 it stays at the opposite level for the whole period.
- R6: `clk_sel_i` = 11 takes ticks from linear divider A and `clk_sel_i` = 12 from divider B. A divider with value N ticks once every N clocks, so X = N in R2 and R3.
- R7: A linear divider set to 0 gives no ticks: no period-end pulse occurs and the output holds its level.
- R8: Changes to period, duty or alignment made in the middle of a period leave that period unchanged and apply from the next period onward.
- R9: While `en_i` is 0 the output follows `pol_i` one clock later and no period-end pulse occurs. On enabling, the counter restarts from 0, so with X = 1 the first period-end pulse comes P clocks after enable.
- R10: `prd_end_o` is a single-clock pulse raised only in the clock after a counter tick that closes a period. With X > 1 it is never high in two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Channel enable |
| clk_sel_i | input | 4 | Tick source: 0..10 power-of-two tap, 11 divider A, 12 divider B |
| align_i | input | 1 | 0 left-aligned, 1 center-aligned |
| pol_i | input | 1 | Output level at the start of a period |
| prd_i | input | 16 | Period value P |
| dty_i | input | 16 | Duty value D |
| div_a_i | input | 8 | Linear divider A ratio (0 stops it) |
| div_b_i | input | 8 | Linear divider B ratio (0 stops it) |
| pwm_o | output | 1 | PWM waveform |
| prd_end_o | output | 1 | One-clock period-end pulse |

## Verification
The hardest case to reach is a configuration change that lands strictly inside a running period. Only the period in progress must keep the old values, so the change has to be timed against the waveform itself. The driver watches the scoreboard queue drain to its last old-configuration entry. That pop happens right at a period boundary, so the driver then waits a few clocks and switches both the period length and the alignment. The monitor then sees one full old period followed by new center-aligned periods.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int SEL_W    = 4;
  localparam int NUM_TAPS = 11;
  localparam int NUM_LDIV = 2;
  localparam logic [SEL_W-1:0] SEL_LDIV_A = SEL_W'(NUM_TAPS);
  localparam logic [SEL_W-1:0] SEL_LDIV_B = SEL_W'(NUM_TAPS + 1);

  typedef enum logic {
    ALIGN_LEFT   = 1'b0,
    ALIGN_CENTER = 1'b1
  } align_e;
endpackage

// File: rtl/pwm_tap_prescaler.sv
module pwm_tap_prescaler #(
  parameter int NUM_TAPS = 11
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                run_i,
  output logic [NUM_TAPS-1:0] tap_o
);
  localparam int CW = (NUM_TAPS > 1) ? NUM_TAPS - 1 : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  assign tap_o[0] = run_i;

  genvar k;
  generate
    for (k = 1; k < NUM_TAPS; k++) begin : g_tap
      assign tap_o[k] = run_i && (&cnt_q[k-1:0]);
    end
  endgenerate
endmodule

// File: rtl/pwm_lin_div.sv
module pwm_lin_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] ratio_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             live;

  assign live   = run_i && (ratio_i != '0);
  assign tick_o = live && (cnt_q >= ratio_i - 1'b1);

  always_ff @(posedge clk_i) begin
    if (rst_i || !live || tick_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_wave_core.sv
module pwm_wave_core
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             align_i,
  input  logic             pol_i,
  input  logic [CNT_W-1:0] prd_i,
  input  logic [CNT_W-1:0] dty_i,
  output logic             pwm_o,
  output logic             prd_end_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             down_q, down_n;
  logic [CNT_W-1:0] prd_q, prd_n, dty_q, dty_n;
  align_e           aln_q, aln_n;
  logic             wrap, load, below, lvl_n;

  always_comb begin
    cnt_n  = cnt_q;
    down_n = down_q;
    wrap   = 1'b0;
    if (!en_i) begin
      cnt_n  = '0;
      down_n = 1'b0;
    end else if (tick_i) begin
      if (aln_q == ALIGN_LEFT) begin
        down_n = 1'b0;
        if (prd_q <= CNT_W'(1) || cnt_q >= prd_q - 1'b1) begin
          cnt_n = '0;
          wrap  = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end else if (prd_q == '0) begin
        cnt_n  = '0;
        down_n = 1'b0;
        wrap   = 1'b1;
      end else if (!down_q) begin
        cnt_n = cnt_q + 1'b1;
        if (cnt_q >= prd_q - 1'b1) down_n = 1'b1;
      end else if (cnt_q <= CNT_W'(1)) begin
        cnt_n  = '0;
        down_n = 1'b0;
        wrap   = 1'b1;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end
  end

  // shadow copies follow the inputs while idle, otherwise only at a boundary
  assign load  = !en_i || wrap;
  assign prd_n = load ? prd_i : prd_q;
  assign dty_n = load ? dty_i : dty_q;
  assign aln_n = load ? align_e'(align_i) : aln_q;

  // falling half compares inclusively so both halves are mirror images
  assign below = down_n ? (cnt_n <= dty_n) : (cnt_n < dty_n);
  assign lvl_n = !en_i ? pol_i : (below ? pol_i : !pol_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q     <= '0;
      down_q    <= 1'b0;
      prd_q     <= '0;
      dty_q     <= '0;
      aln_q     <= ALIGN_LEFT;
      pwm_o     <= 1'b0;
      prd_end_o <= 1'b0;
    end else begin
      cnt_q     <= cnt_n;
      down_q    <= down_n;
      prd_q     <= prd_n;
      dty_q     <= dty_n;
      aln_q     <= aln_n;
      pwm_o     <= lvl_n;
      prd_end_o <= wrap;
    end
  end
endmodule

// File: rtl/pwm_chan_gen.sv
module pwm_chan_gen
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic [3:0]       clk_sel_i,
  input  logic             align_i,
  input  logic             pol_i,
  input  logic [CNT_W-1:0] prd_i,
  input  logic [CNT_W-1:0] dty_i,
  input  logic [DIV_W-1:0] div_a_i,
  input  logic [DIV_W-1:0] div_b_i,
  output logic             pwm_o,
  output logic             prd_end_o
);
  logic [NUM_TAPS-1:0] taps;
  logic [NUM_LDIV-1:0] ldiv_tick;
  logic [DIV_W-1:0]    ldiv_ratio [NUM_LDIV];
  logic                tick_sel;

  assign ldiv_ratio[0] = div_a_i;
  assign ldiv_ratio[1] = div_b_i;

  pwm_tap_prescaler #(.NUM_TAPS(NUM_TAPS)) u_taps (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .run_i (en_i),
    .tap_o (taps)
  );

  genvar d;
  generate
    for (d = 0; d < NUM_LDIV; d++) begin : g_ldiv
      pwm_lin_div #(.DIV_W(DIV_W)) u_div (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .run_i   (en_i),
        .ratio_i (ldiv_ratio[d]),
        .tick_o  (ldiv_tick[d])
      );
    end
  endgenerate

  always_comb begin
    if (clk_sel_i < SEL_W'(NUM_TAPS)) tick_sel = taps[clk_sel_i];
    else if (clk_sel_i == SEL_LDIV_A) tick_sel = ldiv_tick[0];
    else if (clk_sel_i == SEL_LDIV_B) tick_sel = ldiv_tick[1];
    else                              tick_sel = 1'b0;
  end

  pwm_wave_core #(.CNT_W(CNT_W)) u_core (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .en_i      (en_i),
    .tick_i    (tick_sel),
    .align_i   (align_i),
    .pol_i     (pol_i),
    .prd_i     (prd_i),
    .dty_i     (dty_i),
    .pwm_o     (pwm_o),
    .prd_end_o (prd_end_o)
  );
endmodule

// File: rtl/pwm_chan_checker.sv
module pwm_chan_checker #(
  parameter int DIV_W = 8
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             en_i,
  input logic [3:0]       clk_sel_i,
  input logic             pol_i,
  input logic [DIV_W-1:0] div_a_i,
  input logic [DIV_W-1:0] div_b_i,
  input logic             tick_i,
  input logic             pwm_o,
  input logic             prd_end_o
);
  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    rst_i |=> (!pwm_o && !prd_end_o));

  assert_hold_between_ticks_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && !tick_i && $past(en_i) && !$past(rst_i) && (pol_i == $past(pol_i)))
      |=> $stable(pwm_o));

  assert_stopped_div_a_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (clk_sel_i == 4'd11 && div_a_i == '0) |=> !prd_end_o);

  assert_stopped_div_b_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (clk_sel_i == 4'd12 && div_b_i == '0) |=> !prd_end_o);

  assert_idle_follows_pol_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> (!prd_end_o && pwm_o == $past(pol_i)));

  assert_pulse_after_tick_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    prd_end_o |-> $past(en_i && tick_i));
endmodule

bind pwm_chan_gen pwm_chan_checker #(.DIV_W(DIV_W)) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .en_i      (en_i),
  .clk_sel_i (clk_sel_i),
  .pol_i     (pol_i),
  .div_a_i   (div_a_i),
  .div_b_i   (div_b_i),
  .tick_i    (tick_sel),
  .pwm_o     (pwm_o),
  .prd_end_o (prd_end_o)
);

// File: tb/tb_pwm_chan_gen.sv
`timescale 1ns/1ps
module tb_pwm_chan_gen;
  logic        clk = 1'b0;
  logic        rst;
  logic        en;
  logic [3:0]  clk_sel;
  logic        align;
  logic        pol;
  logic [15:0] prd, dty;
  logic [7:0]  div_a, div_b;
  logic        pwm, prd_end;

  pwm_chan_gen dut (
    .clk_i(clk), .rst_i(rst), .en_i(en), .clk_sel_i(clk_sel),
    .align_i(align), .pol_i(pol), .prd_i(prd), .dty_i(dty),
    .div_a_i(div_a), .div_b_i(div_b), .pwm_o(pwm), .prd_end_o(prd_end)
  );

  always #4 clk = ~clk;

  typedef struct { int per; int act; string tag; } exp_t;
  exp_t exp_q[$];

  int checks = 0, errors = 0;
  int cyc = 0;
  bit done = 0;
  int win = 0, act = 0;
  bit armed = 0;
  int pulses = 0;
  bit prev_pulse = 0;
  int consec = 0;

  task automatic check(input bit ok, input string tag, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  // monitor: measures each period between pulses and pops the scoreboard
  always @(negedge clk) begin
    if (rst || !en) begin
      armed = 0;
      prev_pulse = 0;
    end else begin
      if (prd_end) begin
        pulses++;
        if (prev_pulse) consec++;
        if (armed && exp_q.size() > 0) begin
          exp_t e;
          e = exp_q.pop_front();
          check(win == e.per, {e.tag, " period"}, win, e.per);
          check(act == e.act, {e.tag, " active"}, act, e.act);
        end
        win = 1;
        act = (pwm != pol) ? 1 : 0;
        armed = 1;
      end else begin
        win++;
        if (pwm != pol) act++;
      end
      prev_pulse = prd_end;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog (all): actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setup(input logic [3:0] s, input bit a, input bit p,
                       input int pr, input int dt);
    @(negedge clk);
    en = 0; clk_sel = s; align = a; pol = p; prd = 16'(pr); dty = 16'(dt);
    ticks(2);
  endtask

  task automatic push(input int n, input int per, input int ac, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.per = per; e.act = ac; e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    en = 0;
    ticks(3);
  endtask

  task automatic run_cfg(input logic [3:0] s, input bit a, input bit p, input int pr,
                         input int dt, input int x, input string tag);
    int per, ac;
    setup(s, a, p, pr, dt);
    per = (a ? 2 : 1) * x * pr;
    ac  = (dt >= pr) ? 0 : (a ? 2 : 1) * x * (pr - dt);
    push(3, per, ac, tag);
    en = 1;
    drain();
  endtask

  initial begin
    rst = 1; en = 0; clk_sel = 0; align = 0; pol = 0;
    prd = 16'd4; dty = 16'd2; div_a = 8'd3; div_b = 8'd5;
    ticks(3);
    check(pwm == 1'b0, "R1 pwm in reset", pwm, 0);
    check(prd_end == 1'b0, "R1 pulse in reset", prd_end, 0);
    rst = 0;
    @(negedge clk);
    check(pwm == 1'b0 && prd_end == 1'b0, "R1 after reset", {pwm, prd_end}, 0);

    run_cfg(4'd0,  0, 0, 10, 3, 1,    "R2 left x1");
    run_cfg(4'd2,  0, 0, 5,  2, 4,    "R2 left x4");
    run_cfg(4'd10, 0, 0, 2,  1, 1024, "R2 left x1024");
    run_cfg(4'd1,  1, 0, 6,  2, 2,    "R3 center x2");
    run_cfg(4'd0,  1, 0, 1,  0, 1,    "R3 center p1");
    run_cfg(4'd3,  1, 0, 4,  1, 8,    "R3 center x8");
    run_cfg(4'd0,  0, 1, 8,  5, 1,    "R4 pol high left");
    run_cfg(4'd1,  1, 1, 5,  3, 2,    "R4 pol high center");
    run_cfg(4'd0,  0, 0, 4,  6, 1,    "R5 duty above period");
    run_cfg(4'd0,  0, 0, 4,  0, 1,    "R5 duty zero");
    run_cfg(4'd0,  1, 1, 3,  3, 1,    "R5 center duty equal");
    div_a = 8'd3;
    run_cfg(4'd11, 0, 0, 4,  1, 3,    "R6 divider A");
    div_b = 8'd5;
    run_cfg(4'd12, 1, 0, 3,  1, 5,    "R6 divider B");

    // R7: stopped divider
    div_a = 8'd0;
    setup(4'd11, 0, 1, 4, 2);
    pulses = 0;
    en = 1;
    ticks(200);
    check(pulses == 0, "R7 no pulse with divider 0", pulses, 0);
    check(pwm == 1'b1, "R7 output holds", pwm, 1);
    en = 0; ticks(3);
    div_a = 8'd3;

    // R8: mid-period reconfiguration
    setup(4'd0, 0, 0, 10, 4);
    push(2, 10, 6, "R8 old config");
    en = 1;
    while (exp_q.size() > 1) @(negedge clk);
    ticks(3);
    prd = 16'd6; dty = 16'd1; align = 1;
    push(2, 12, 10, "R8 new config");
    drain();

    // R9: idle behaviour and restart
    setup(4'd0, 0, 1, 5, 2);
    en = 1; ticks(12); en = 0;
    pulses = 0;
    ticks(20);
    check(pulses == 0, "R9 no pulse while idle", pulses, 0);
    check(pwm == 1'b1, "R9 idle pol high", pwm, 1);
    pol = 0; ticks(2);
    check(pwm == 1'b0, "R9 idle pol low", pwm, 0);
    begin
      int n = 0;
      en = 1;
      do begin @(negedge clk); n++; end while (!prd_end && n < 50);
      check(n == 5, "R9 first pulse after enable", n, 5);
    end
    en = 0; ticks(3);

    // R10: pulse width with x2 ticks and P=1
    setup(4'd1, 0, 0, 1, 0);
    pulses = 0; consec = 0;
    en = 1; ticks(40);
    check(consec == 0, "R10 no back-to-back pulse", consec, 0);
    check(pulses >= 18 && pulses <= 21, "R10 pulse count", pulses, 20);
    en = 0; ticks(3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule